// File: doc/BRIEF.md
# Low-Power Mode and Reset Sequencer

This block decides when a small 8-bit controller runs, sleeps or restarts. It runs on the raw oscillator clock and produces enables rather than gated clocks. The CPU tick fires on one oscillator cycle in three. A USB tick fires on one cycle in four for a 24 MHz crystal, or one in two when the divider-select input marks a 12 MHz crystal. On request the block enters one of two sleep states. In the light sleep only the CPU is held and every interrupt wakes it. In the deep sleep the oscillator is switched off, so every tick stops, and only an external pin interrupt, a USB resume event or a reset brings it back.

Whenever the oscillator starts again, the CPU is held for a fixed number of CPU ticks. This happens after power-up, after any reset source and after leaving deep sleep. The default is 4096 ticks, and it is a parameter so that simulation can shorten it. When the hold ends, a one-cycle strobe tells the core what to do next: fetch the reset vector, or service the interrupt that woke it. A pulse on the external reset pin is accepted only if it is at least one and a half CPU periods long. Watchdog and low-voltage resets pull the shared reset pin low through an open-drain enable, so that the rest of the board restarts with the controller.

Top module: `lpm_seq_top`

## Requirements
- R1: After power-on reset or any accepted reset source, `stabilizing` is high for exactly 3 x STAB_CYCLES oscillator cycles after the last cycle the source was active. Then `vecFetch` pulses high for one cycle, with `serviceIrq` low.
- R2: In the run state, `cpuClkEn` and `periphClkEn` are each high on exactly one oscillator cycle in every three.
- R3: While the oscillator runs, `usbClkEn` is high on one cycle in four when `usbDivSel`=0, and on one cycle in two when `usbDivSel`=1.
- R4: In light sleep (entered by `waitReq` in run), `cpuClkEn` stays low, `periphClkEn` keeps its one-in-three rate, `oscEn` stays high and `irqMaskClr` is high.
- R5: An `anyIrq` during light sleep returns to run at the next edge, with a one-cycle `serviceIrq` pulse and no stabilisation hold.
- R6: In deep sleep (entered by `haltReq` in run; `haltReq` wins when both requests arrive together), `oscEn`, `cpuClkEn`, `periphClkEn` and `usbClkEn` are low and `irqMaskClr` is high.
- R7: In deep sleep, `anyIrq` has no effect. `extWake` or `usbResume` starts a stabilisation hold of 3 x STAB_CYCLES cycles, which ends with `serviceIrq` (not `vecFetch`).
- R8: `extRstN` low for 5 or more consecutive oscillator cycles is accepted as a reset, which ends in `vecFetch`. A low pulse of 4 cycles is ignored.
- R9: `wdogTrip` or `lowVolt` drives `resetPinDrvN` low from the trip until the stabilisation hold ends. An external pin reset never drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (model) |
| porN | input | 1 | Asynchronous power-on reset, active low |
| haltReq | input | 1 | Deep-sleep request from the core |
| waitReq | input | 1 | Light-sleep request from the core |
| anyIrq | input | 1 | Any pending interrupt |
| extWake | input | 1 | External pin interrupt |
| usbResume | input | 1 | USB end-of-suspend event |
| extRstN | input | 1 | Reset pin level, active low |
| wdogTrip | input | 1 | Watchdog reset pulse |
| lowVolt | input | 1 | Supply-low flag |
| usbDivSel | input | 1 | 1: 12 MHz crystal, USB tick every 2 cycles |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU tick enable |
| periphClkEn | output | 1 | Peripheral tick enable |
| usbClkEn | output | 1 | USB tick enable |
| irqMaskClr | output | 1 | Force the interrupt mask to 0 |
| vecFetch | output | 1 | One-cycle strobe: fetch the reset vector |
| serviceIrq | output | 1 | One-cycle strobe: service the waking interrupt |
| resetPinDrvN | output | 1 | Open-drain reset pin drive, 0 pulls low |
| stabilizing | output | 1 | Stabilisation hold in progress |

## Verification
The bench measures the exact length of each stabilisation hold. An off-by-one in the tick divider or the hold counter shows up as a hold of the wrong length, measured from power-up, a watchdog pulse, a supply dip and both deep-sleep wake sources. It checks the external reset filter right at its boundary (4 cycles rejected, 5 accepted), which catches a filter that is one cycle short or long. It checks that an ordinary interrupt cannot end deep sleep, that light sleep resumes with no hold, and that halt wins over wait. A design that mixed up the wake reason would fetch the vector after an interrupt wake. One that forgot to latch the pin drive would release the board reset early.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_HALT = 2'd2,
    ST_STAB = 2'd3
  } lpmState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic oscOn;
    logic divClr;
    logic stabClr;
    logic stabRun;
  } seqStrobe_t;
endpackage

// File: rtl/lpm_seq_dpath.sv
module lpm_seq_dpath
  import lpm_seq_pkg::*;
#(
  parameter int CPU_DIV      = 3,
  parameter int STAB_CYCLES  = 4096,
  parameter int USB_SLOW_DIV = 4,
  parameter int USB_FAST_DIV = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  seqStrobe_t strb,
  input  logic       extRstN,
  input  logic       usbDivSel,
  output logic       tick,
  output logic       stabDone,
  output logic       extRstEvt,
  output logic       usbClkEn
);
  localparam int DW   = (CPU_DIV > 1) ? $clog2(CPU_DIV) : 1;
  localparam int QUAL = (3 * CPU_DIV + 1) / 2;   // 1.5 CPU periods, rounded up
  localparam int QW   = $clog2(QUAL + 1);
  localparam int SW   = $clog2(STAB_CYCLES + 1);
  localparam int UW   = (USB_SLOW_DIV > 1) ? $clog2(USB_SLOW_DIV) : 1;

  logic [DW-1:0] divCnt;
  logic [1:0]    extSync;
  logic [QW-1:0] extCnt;
  logic [SW-1:0] stabCnt;
  logic [UW-1:0] usbCnt;
  logic [UW-1:0] usbLim;

  // CPU tick divider
  assign tick = strb.oscOn && (divCnt == DW'(CPU_DIV - 1));

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                           divCnt <= '0;
    else if (!strb.oscOn || strb.divClr) divCnt <= '0;
    else if (tick)                       divCnt <= '0;
    else                                 divCnt <= divCnt + 1'b1;
  end

  // reset pin synchroniser and width qualifier
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      extSync <= 2'b11;
      extCnt  <= '0;
    end else begin
      extSync <= {extSync[0], extRstN};
      if (extSync[1])                extCnt <= '0;
      else if (extCnt != QW'(QUAL))  extCnt <= extCnt + 1'b1;
    end
  end

  assign extRstEvt = (extCnt == QW'(QUAL));

  // stabilisation counter, counts CPU ticks
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                      stabCnt <= '0;
    else if (strb.stabClr)          stabCnt <= '0;
    else if (strb.stabRun && tick)  stabCnt <= stabCnt + 1'b1;
  end

  assign stabDone = strb.stabRun && tick && (stabCnt == SW'(STAB_CYCLES - 1));

  // USB tick divider
  assign usbLim = usbDivSel ? UW'(USB_FAST_DIV - 1) : UW'(USB_SLOW_DIV - 1);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               usbCnt <= '0;
    else if (!strb.oscOn)    usbCnt <= '0;
    else if (usbCnt >= usbLim) usbCnt <= '0;
    else                     usbCnt <= usbCnt + 1'b1;
  end

  assign usbClkEn = strb.oscOn && (usbCnt == usbLim);
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
  import lpm_seq_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       haltReq,
  input  logic       waitReq,
  input  logic       anyIrq,
  input  logic       extWake,
  input  logic       usbResume,
  input  logic       wdogTrip,
  input  logic       lowVolt,
  input  logic       tick,
  input  logic       stabDone,
  input  logic       extRstEvt,
  output seqStrobe_t strb,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       irqMaskClr,
  output logic       stabilizing,
  output logic       vecFetch,
  output logic       serviceIrq,
  output logic       resetPinDrvN
);
  lpmState_e state, stateNx;
  logic wakeRst, wakeRstNx;
  logic drvHold, drvHoldNx;
  logic vecNx, svcNx;
  logic rstSrc, pinSrc;

  assign pinSrc = wdogTrip | lowVolt;
  assign rstSrc = pinSrc | extRstEvt;

  always_comb begin
    stateNx      = state;
    wakeRstNx    = wakeRst;
    drvHoldNx    = drvHold;
    vecNx        = 1'b0;
    svcNx        = 1'b0;
    strb.oscOn   = (state != ST_HALT);
    strb.stabRun = (state == ST_STAB);
    strb.divClr  = 1'b0;
    strb.stabClr = 1'b0;
    if (rstSrc) begin
      stateNx      = ST_STAB;
      wakeRstNx    = 1'b1;
      drvHoldNx    = drvHold | pinSrc;
      strb.divClr  = 1'b1;
      strb.stabClr = 1'b1;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (haltReq)      stateNx = ST_HALT;
          else if (waitReq) stateNx = ST_WAIT;
        end
        ST_WAIT: begin
          if (anyIrq) begin
            stateNx = ST_RUN;
            svcNx   = 1'b1;
          end
        end
        ST_HALT: begin
          if (extWake || usbResume) begin
            stateNx      = ST_STAB;
            wakeRstNx    = 1'b0;
            strb.divClr  = 1'b1;
            strb.stabClr = 1'b1;
          end
        end
        ST_STAB: begin
          if (stabDone) begin
            stateNx   = ST_RUN;
            vecNx     = wakeRst;
            svcNx     = !wakeRst;
            drvHoldNx = 1'b0;
          end
        end
        default: stateNx = ST_STAB;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state      <= ST_STAB;
      wakeRst    <= 1'b1;
      drvHold    <= 1'b0;
      vecFetch   <= 1'b0;
      serviceIrq <= 1'b0;
    end else begin
      state      <= stateNx;
      wakeRst    <= wakeRstNx;
      drvHold    <= drvHoldNx;
      vecFetch   <= vecNx;
      serviceIrq <= svcNx;
    end
  end

  assign cpuClkEn     = tick && (state == ST_RUN);
  assign periphClkEn  = tick && (state == ST_RUN || state == ST_WAIT);
  assign irqMaskClr   = (state == ST_WAIT) || (state == ST_HALT);
  assign stabilizing  = (state == ST_STAB);
  assign resetPinDrvN = !(drvHold | pinSrc);
endmodule

// File: rtl/lpm_seq_top.sv
module lpm_seq_top
  import lpm_seq_pkg::*;
#(
  parameter int CPU_DIV      = 3,
  parameter int STAB_CYCLES  = 4096,
  parameter int USB_SLOW_DIV = 4,
  parameter int USB_FAST_DIV = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic haltReq,
  input  logic waitReq,
  input  logic anyIrq,
  input  logic extWake,
  input  logic usbResume,
  input  logic extRstN,
  input  logic wdogTrip,
  input  logic lowVolt,
  input  logic usbDivSel,
  output logic oscEn,
  output logic cpuClkEn,
  output logic periphClkEn,
  output logic usbClkEn,
  output logic irqMaskClr,
  output logic vecFetch,
  output logic serviceIrq,
  output logic resetPinDrvN,
  output logic stabilizing
);
  seqStrobe_t strb;
  logic tick, stabDone, extRstEvt;

  lpm_seq_ctrl i_ctrl (
    .clk(clk), .porN(porN), .haltReq(haltReq), .waitReq(waitReq),
    .anyIrq(anyIrq), .extWake(extWake), .usbResume(usbResume),
    .wdogTrip(wdogTrip), .lowVolt(lowVolt), .tick(tick),
    .stabDone(stabDone), .extRstEvt(extRstEvt), .strb(strb),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .irqMaskClr(irqMaskClr),
    .stabilizing(stabilizing), .vecFetch(vecFetch), .serviceIrq(serviceIrq),
    .resetPinDrvN(resetPinDrvN)
  );

  lpm_seq_dpath #(
    .CPU_DIV(CPU_DIV), .STAB_CYCLES(STAB_CYCLES),
    .USB_SLOW_DIV(USB_SLOW_DIV), .USB_FAST_DIV(USB_FAST_DIV)
  ) i_dpath (
    .clk(clk), .porN(porN), .strb(strb), .extRstN(extRstN),
    .usbDivSel(usbDivSel), .tick(tick), .stabDone(stabDone),
    .extRstEvt(extRstEvt), .usbClkEn(usbClkEn)
  );

  assign oscEn = strb.oscOn;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic clk,
  input logic porN,
  input logic wdogTrip,
  input logic lowVolt,
  input logic oscEn,
  input logic cpuClkEn,
  input logic periphClkEn,
  input logic usbClkEn,
  input logic irqMaskClr,
  input logic vecFetch,
  input logic serviceIrq,
  input logic resetPinDrvN,
  input logic stabilizing
);
  // R6
  halt_clocks_off_chk: assert property (@(posedge clk) disable iff (!porN)
    !oscEn |-> (!cpuClkEn && !periphClkEn && !usbClkEn && irqMaskClr));

  // R1
  vec_after_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    vecFetch |-> $past(stabilizing));

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!porN)
    $countones({vecFetch, serviceIrq}) <= 1);

  // R2
  cpu_tick_gap_chk: assert property (@(posedge clk) disable iff (!porN)
    cpuClkEn |=> !cpuClkEn);

  // R9
  pin_drive_chk: assert property (@(posedge clk) disable iff (!porN)
    (wdogTrip || lowVolt) |=> (!resetPinDrvN && stabilizing));

  // R1
  hold_no_cpu_chk: assert property (@(posedge clk) disable iff (!porN)
    stabilizing |-> (!cpuClkEn && !periphClkEn));
endmodule

bind lpm_seq_top lpm_seq_chk i_lpm_seq_chk (
  .clk(clk), .porN(porN), .wdogTrip(wdogTrip), .lowVolt(lowVolt),
  .oscEn(oscEn), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
  .usbClkEn(usbClkEn), .irqMaskClr(irqMaskClr), .vecFetch(vecFetch),
  .serviceIrq(serviceIrq), .resetPinDrvN(resetPinDrvN),
  .stabilizing(stabilizing)
);

// File: tb/test_lpm_seq_top.sv
module test_lpm_seq_top;
  localparam int STAB = 6;
  localparam int HOLD = 3 * STAB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic porN, haltReq, waitReq, anyIrq, extWake, usbResume;
  logic extRstN, wdogTrip, lowVolt, usbDivSel;
  logic oscEn, cpuClkEn, periphClkEn, usbClkEn, irqMaskClr;
  logic vecFetch, serviceIrq, resetPinDrvN, stabilizing;

  int checks = 0;
  int fails  = 0;

  lpm_seq_top #(.STAB_CYCLES(STAB)) i_lpm_seq_top (
    .clk(clk), .porN(porN), .haltReq(haltReq), .waitReq(waitReq),
    .anyIrq(anyIrq), .extWake(extWake), .usbResume(usbResume),
    .extRstN(extRstN), .wdogTrip(wdogTrip), .lowVolt(lowVolt),
    .usbDivSel(usbDivSel), .oscEn(oscEn), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .usbClkEn(usbClkEn), .irqMaskClr(irqMaskClr),
    .vecFetch(vecFetch), .serviceIrq(serviceIrq), .resetPinDrvN(resetPinDrvN),
    .stabilizing(stabilizing)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic measHold(output int n);
    n = 0;
    while (stabilizing && n < 1000) begin
      n++;
      step();
    end
  endtask

  task automatic window(input int len, output int c, output int p, output int u,
                        output int m, output int o);
    c = 0; p = 0; u = 0; m = 0; o = 0;
    for (int i = 0; i < len; i++) begin
      c += int'(cpuClkEn);
      p += int'(periphClkEn);
      u += int'(usbClkEn);
      m += int'(irqMaskClr);
      o += int'(oscEn);
      step();
    end
  endtask

  initial begin
    int n, c, p, u, m, o;
    int pinLowCnt;
    bit sawStab, sawVec, pinDriven;
    porN = 0; haltReq = 0; waitReq = 0; anyIrq = 0; extWake = 0;
    usbResume = 0; extRstN = 1; wdogTrip = 0; lowVolt = 0; usbDivSel = 0;
    repeat (3) step();
    // R1 reset state
    chk(stabilizing == 1'b1, "R1 reset stabilizing", int'(stabilizing), 1);
    chk(vecFetch == 1'b0 && cpuClkEn == 1'b0, "R1 reset strobes", int'(vecFetch), 0);
    porN = 1;
    measHold(n);
    chk(n == HOLD, "R1 power-up hold length", n, HOLD);
    chk(vecFetch == 1'b1 && serviceIrq == 1'b0, "R1 vector fetch after power-up", int'(vecFetch), 1);
    step();
    chk(vecFetch == 1'b0, "R1 vector strobe one cycle", int'(vecFetch), 0);

    // R2, R3 run rates
    window(24, c, p, u, m, o);
    chk(c == 8, "R2 cpu ticks in 24", c, 8);
    chk(p == 8, "R2 periph ticks in 24", p, 8);
    chk(u == 6, "R3 usb ticks div4", u, 6);
    usbDivSel = 1;
    step();
    window(24, c, p, u, m, o);
    chk(u == 12, "R3 usb ticks div2", u, 12);
    usbDivSel = 0;

    // R4 light sleep
    waitReq = 1; step(); waitReq = 0;
    window(24, c, p, u, m, o);
    chk(c == 0, "R4 cpu stopped in wait", c, 0);
    chk(p == 8, "R4 periph running in wait", p, 8);
    chk(m == 24 && o == 24, "R4 mask clear and osc on", m, 24);
    // R5 wake from wait
    anyIrq = 1; step(); anyIrq = 0;
    chk(serviceIrq == 1'b1 && stabilizing == 1'b0, "R5 irq wake from wait", int'(serviceIrq), 1);
    window(24, c, p, u, m, o);
    chk(c == 8, "R5 cpu resumes after wait", c, 8);

    // R6 deep sleep, halt wins over wait
    haltReq = 1; waitReq = 1; step(); haltReq = 0; waitReq = 0;
    window(12, c, p, u, m, o);
    chk(o == 0 && c == 0 && p == 0 && u == 0, "R6 all clocks off in halt", o + c + p + u, 0);
    chk(m == 12, "R6 mask clear in halt", m, 12);
    // R7 plain interrupt ignored
    anyIrq = 1; step(); anyIrq = 0;
    window(6, c, p, u, m, o);
    chk(o == 0 && serviceIrq == 1'b0, "R7 anyIrq ignored in halt", o, 0);
    extWake = 1; step(); extWake = 0;
    measHold(n);
    chk(n == HOLD, "R7 hold after pin wake", n, HOLD);
    chk(serviceIrq == 1'b1 && vecFetch == 1'b0, "R7 service after pin wake", int'(serviceIrq), 1);
    haltReq = 1; step(); haltReq = 0;
    repeat (4) step();
    usbResume = 1; step(); usbResume = 0;
    measHold(n);
    chk(n == HOLD, "R7 hold after usb resume", n, HOLD);
    chk(serviceIrq == 1'b1 && vecFetch == 1'b0, "R7 service after usb resume", int'(serviceIrq), 1);

    // R9 watchdog
    step();
    wdogTrip = 1; step(); wdogTrip = 0;
    chk(resetPinDrvN == 1'b0, "R9 pin driven on watchdog", int'(resetPinDrvN), 0);
    measHold(n);
    chk(n == HOLD, "R1 hold after watchdog", n, HOLD);
    chk(vecFetch == 1'b1 && resetPinDrvN == 1'b1, "R9 vector fetch and pin released", int'(resetPinDrvN), 1);

    // R9 low voltage
    lowVolt = 1;
    pinLowCnt = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      pinLowCnt += int'(!resetPinDrvN && stabilizing);
    end
    chk(pinLowCnt == 8, "R9 pin low during supply dip", pinLowCnt, 8);
    lowVolt = 0;
    pinLowCnt = 0;
    n = 0;
    while (stabilizing && n < 1000) begin
      n++;
      pinLowCnt += int'(!resetPinDrvN);
      step();
    end
    chk(n == HOLD, "R1 hold after supply dip", n, HOLD);
    chk(pinLowCnt == HOLD, "R9 pin held through hold", pinLowCnt, HOLD);
    chk(resetPinDrvN == 1'b1 && vecFetch == 1'b1, "R9 pin released after dip", int'(resetPinDrvN), 1);

    // R8 short external pulse rejected
    repeat (3) step();
    extRstN = 0;
    repeat (4) step();
    extRstN = 1;
    sawStab = 0;
    for (int i = 0; i < 10; i++) begin
      sawStab |= stabilizing;
      step();
    end
    chk(sawStab == 1'b0, "R8 four-cycle pulse ignored", int'(sawStab), 0);
    // R8 five-cycle pulse accepted, pin not driven
    extRstN = 0;
    repeat (5) step();
    extRstN = 1;
    sawStab = 0; sawVec = 0; pinDriven = 0;
    for (int i = 0; i < 100; i++) begin
      sawStab   |= stabilizing;
      sawVec    |= vecFetch;
      pinDriven |= !resetPinDrvN;
      step();
    end
    chk(sawStab && sawVec, "R8 five-cycle pulse accepted", int'(sawVec), 1);
    chk(pinDriven == 1'b0, "R9 external reset does not drive pin", int'(pinDriven), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule